// File: doc/BRIEF.md
# Selectable Clock Gate Controller

This block decides whether one downstream clock is on or off. It drives an enable signal into a glitch-free clock gate, which sits outside the block. The choice comes from one of two places. The first is a hardware activity request, which gives automatic gating. The second is an enable field that software writes. A mode field in the same 32-bit register word chooses which of the two is in charge.

A read-only status field shows the gate state with a fixed two-cycle lag. This lag stands in for synchronization latency, so software can poll the field until a change it asked for has settled.

A build-time parameter selects one of five variants:
- no gate at all, so the clock is always on;
- hardware-only;
- software-only;
- selectable;
- hardware-or-on, which is forced on whenever hardware is not in control.

The selectable variant has a second parameter that picks whether it leaves reset under software control or under hardware control. The register port is a plain single-word write strobe with data, plus a read-data bus that always shows the word.

Top module: `cgate_ctrl`

## Requirements
- R1: The register word has the enable field at bit 0, the mode field at bit 4 and the status field at bit 8. Every other bit reads 0, and a field the variant lacks reads 0. The one exception is R7.
- R2: In the selectable variant, a mode field of 0 makes `gate_en` follow `hw_req`. A mode field of 1 makes `gate_en` follow the enable field.
- R3: Wherever software is in control, an enable field of 1 turns the gate on and 0 turns it off.
- R4: The status field equals the value `gate_en` had two rising clock edges earlier. Reset clears it to 0.
- R5: In the hardware-only variant, `gate_en` follows `hw_req`. Writes have no effect, and the enable and mode fields read 0.
- R6: In the software-only variant, `gate_en` follows the enable field and `hw_req` is ignored. The mode field reads 0 and writes to it are ignored.
- R7: In the hardware-or-on variant, a mode field of 0 makes `gate_en` follow `hw_req`, and a mode field of 1 forces `gate_en` to 1. The enable field always reads 1 and writes to it are ignored.
- R8: In the no-gate variant, `gate_en` is always 1 and writes have no effect.
- R9: Reset values:
  - software-only: enable 1;
  - selectable built for software start: mode 1, enable 1;
  - selectable built for hardware start: mode 0, enable 0;
  - hardware-or-on: mode 0.
- R10: A write on a rising edge with `wr_en` high updates the fields present from `wr_data`. The read word and `gate_en` show the new values from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write word |
| hw_req | input | 1 | Hardware activity request (1 = clock needed) |
| rd_data | output | 32 | Register read word |
| gate_en | output | 1 | Enable to the downstream clock gate |

## Verification
Six copies of the block, one for each variant plus both reset choices of the selectable one, receive the same stimulus. The stimulus has four parts:
- `hw_req` toggling while hardware is in control, which separates the variants that follow the request from those that ignore it;
- writes that switch the mode field with `hw_req` held opposite to the enable field, which shows which source really drives the gate;
- all-ones and all-zeros writes, which expose writable or nonzero bits that should be absent;
- a long pseudo-random run with a reset in the middle, which exercises the two-cycle status lag at every kind of transition.

// File: rtl/cgate_pkg.sv
// Shared definitions for the clock gate controller.
// Assumes a 32-bit register view; field positions are parameters of the top.
package cgate_pkg;
    typedef enum logic [2:0] {
        GK_NONE       = 3'd0,
        GK_HW_ONLY    = 3'd1,
        GK_SW_ONLY    = 3'd2,
        GK_SELECTABLE = 3'd3,
        GK_HW_OR_ON   = 3'd4
    } gate_kind_e;
endpackage

// File: rtl/cgate_fields.sv
// Writable enable and mode fields. A field that is absent is tied to a
// constant. Assumes a single register word written with a strobe.
module cgate_fields #(
    parameter int   REG_W   = 32,
    parameter int   EN_POS  = 0,
    parameter int   SEL_POS = 4,
    parameter bit   HAS_EN  = 1'b1,
    parameter bit   HAS_SEL = 1'b1,
    parameter logic EN_RST  = 1'b1,
    parameter logic SEL_RST = 1'b1,
    parameter logic EN_TIE  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             en_q,
    output logic             sel_q
);
    generate
        if (HAS_EN) begin : g_en
            // Hold the software enable field.
            always_ff @(posedge clk) begin
                if (!rst_n)     en_q <= EN_RST;
                else if (wr_en) en_q <= wr_data[EN_POS];
            end
        end else begin : g_no_en
            assign en_q = EN_TIE;
        end

        if (HAS_SEL) begin : g_sel
            // Hold the hardware/software mode field.
            always_ff @(posedge clk) begin
                if (!rst_n)     sel_q <= SEL_RST;
                else if (wr_en) sel_q <= wr_data[SEL_POS];
            end
        end else begin : g_no_sel
            assign sel_q = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cgate_arbiter.sv
// Picks the effective gate enable from the variant, the mode field,
// the software enable and the hardware request. Purely combinational.
module cgate_arbiter
    import cgate_pkg::*;
#(
    parameter gate_kind_e KIND = GK_SELECTABLE
) (
    input  logic en_q,
    input  logic sel_q,
    input  logic hw_req,
    output logic gate_on
);
    // Resolve which source controls the gate.
    always_comb begin
        case (KIND)
            GK_NONE:       gate_on = 1'b1;
            GK_HW_ONLY:    gate_on = hw_req;
            GK_SW_ONLY:    gate_on = en_q;
            GK_SELECTABLE: gate_on = sel_q ? en_q : hw_req;
            GK_HW_OR_ON:   gate_on = sel_q ? 1'b1 : hw_req;
            default:       gate_on = 1'b1;
        endcase
    end
endmodule

// File: rtl/cgate_status_pipe.sv
// Delays the effective enable by STAGES clock edges to form the status
// field. Reset clears every stage. Assumes STAGES >= 1.
module cgate_status_pipe #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One synchronizer-like delay stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= 1'b0;
                else        stage_q[s] <= (s == 0) ? d : stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cgate_ctrl.sv
// Clock gate control cell with a single 32-bit register word.
// Fields: software enable, hardware/software mode and read-only status.
// The variant is fixed at build time by KIND. The gate enable is
// combinational from the fields and hw_req. hw_req is assumed
// synchronous to clk.
module cgate_ctrl
    import cgate_pkg::*;
#(
    parameter gate_kind_e KIND       = GK_SELECTABLE,
    parameter bit         SW_INIT    = 1'b1,
    parameter int         REG_W      = 32,
    parameter int         EN_POS     = 0,
    parameter int         SEL_POS    = 4,
    parameter int         STAT_POS   = 8,
    parameter int         LAG_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hw_req,
    output logic [REG_W-1:0] rd_data,
    output logic             gate_en
);
    localparam bit HAS_EN  = (KIND == GK_SW_ONLY) || (KIND == GK_SELECTABLE);
    localparam bit HAS_SEL = (KIND == GK_SELECTABLE) || (KIND == GK_HW_OR_ON);
    localparam logic EN_RST  = (KIND == GK_SW_ONLY) ? 1'b1 :
                               (KIND == GK_SELECTABLE) ? SW_INIT : 1'b0;
    localparam logic SEL_RST = (KIND == GK_SELECTABLE) ? SW_INIT : 1'b0;
    localparam logic EN_TIE  = (KIND == GK_HW_OR_ON);

    logic en_q, sel_q, gate_on, status_q;

    cgate_fields #(
        .REG_W(REG_W), .EN_POS(EN_POS), .SEL_POS(SEL_POS),
        .HAS_EN(HAS_EN), .HAS_SEL(HAS_SEL),
        .EN_RST(EN_RST), .SEL_RST(SEL_RST), .EN_TIE(EN_TIE)
    ) u_fields (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .en_q(en_q), .sel_q(sel_q)
    );

    cgate_arbiter #(.KIND(KIND)) u_arb (
        .en_q(en_q), .sel_q(sel_q), .hw_req(hw_req), .gate_on(gate_on)
    );

    cgate_status_pipe #(.STAGES(LAG_STAGES)) u_stat (
        .clk(clk), .rst_n(rst_n), .d(gate_on), .q(status_q)
    );

    assign gate_en = gate_on;

    // Assemble the read word from the fields.
    always_comb begin
        rd_data           = '0;
        rd_data[EN_POS]   = en_q;
        rd_data[SEL_POS]  = sel_q;
        rd_data[STAT_POS] = status_q;
    end
endmodule

// File: rtl/cgate_ctrl_chk.sv
// Checker for cgate_ctrl, attached to it with bind. It watches only the
// ports. A small counter makes sure that the status lag check looks back
// only over cycles that came after reset.
module cgate_ctrl_chk
    import cgate_pkg::*;
#(
    parameter gate_kind_e KIND     = GK_SELECTABLE,
    parameter bit         SW_INIT  = 1'b1,
    parameter int         REG_W    = 32,
    parameter int         EN_POS   = 0,
    parameter int         SEL_POS  = 4,
    parameter int         STAT_POS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             hw_req,
    input logic [REG_W-1:0] rd_data,
    input logic             gate_en
);
    localparam logic [REG_W-1:0] FIELD_MASK =
        (REG_W'(1) << EN_POS) | (REG_W'(1) << SEL_POS) | (REG_W'(1) << STAT_POS);

    logic [1:0] since_rst;
    // Count edges since reset, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    assert_status_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (rd_data[STAT_POS] == $past(gate_en, 2)));

    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~FIELD_MASK) == '0);

    generate
        if (KIND == GK_NONE) begin : g_none
            assert_always_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
                gate_en);
        end
        if (KIND == GK_HW_ONLY) begin : g_hw
            assert_follow_hw_R5: assert property (@(posedge clk) disable iff (!rst_n)
                gate_en == hw_req);
        end
        if (KIND == GK_SW_ONLY) begin : g_sw
            assert_follow_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
                gate_en == rd_data[EN_POS]);
        end
        if (KIND == GK_SELECTABLE) begin : g_sel
            assert_hw_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_data[SEL_POS] |-> (gate_en == hw_req));
            assert_sw_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
                rd_data[SEL_POS] |-> (gate_en == rd_data[EN_POS]));
            assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> (rd_data[SEL_POS] == $past(wr_data[SEL_POS])) &&
                          (rd_data[EN_POS] == $past(wr_data[EN_POS])));
            assert_reset_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> (rd_data[SEL_POS] == SW_INIT) && (rd_data[EN_POS] == SW_INIT));
        end
        if (KIND == GK_HW_OR_ON) begin : g_hwon
            assert_forced_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
                rd_data[SEL_POS] |-> gate_en);
            assert_en_reads_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
                rd_data[EN_POS]);
        end
    endgenerate
endmodule

bind cgate_ctrl cgate_ctrl_chk #(
    .KIND(KIND), .SW_INIT(SW_INIT), .REG_W(REG_W),
    .EN_POS(EN_POS), .SEL_POS(SEL_POS), .STAT_POS(STAT_POS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_req(hw_req), .rd_data(rd_data), .gate_en(gate_en)
);

// File: tb/test_cgate_ctrl.sv
// Bench: six copies of the block, covering every variant, share one
// stimulus. A behavioural model is compared against them on every cycle.
module test_cgate_ctrl;
    import cgate_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NINST      = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        hw_req = 1'b0;
    logic [31:0] rd_v [NINST];
    logic        ge_v [NINST];

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    bit started = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cgate_ctrl #(.KIND(GK_NONE)) i_cgate_ctrl_none (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hw_req(hw_req), .rd_data(rd_v[0]), .gate_en(ge_v[0]));
    cgate_ctrl #(.KIND(GK_HW_ONLY)) i_cgate_ctrl_hw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hw_req(hw_req), .rd_data(rd_v[1]), .gate_en(ge_v[1]));
    cgate_ctrl #(.KIND(GK_SW_ONLY)) i_cgate_ctrl_sw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hw_req(hw_req), .rd_data(rd_v[2]), .gate_en(ge_v[2]));
    cgate_ctrl #(.KIND(GK_SELECTABLE), .SW_INIT(1'b1)) i_cgate_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hw_req(hw_req), .rd_data(rd_v[3]), .gate_en(ge_v[3]));
    cgate_ctrl #(.KIND(GK_HW_OR_ON)) i_cgate_ctrl_hwon (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hw_req(hw_req), .rd_data(rd_v[4]), .gate_en(ge_v[4]));
    cgate_ctrl #(.KIND(GK_SELECTABLE), .SW_INIT(1'b0)) i_cgate_ctrl_selhw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hw_req(hw_req), .rd_data(rd_v[5]), .gate_en(ge_v[5]));

    // Model state: variant code (0 none,1 hw,2 sw,3 sel,4 hw-or-on), fields, status lag.
    int kind_of [NINST] = '{0, 1, 2, 3, 4, 3};
    int sw_init [NINST] = '{0, 0, 0, 1, 0, 0};
    int m_en  [NINST];
    int m_sel [NINST];
    int hist  [NINST][$];

    function automatic int model_gate(int i, int hw);
        case (kind_of[i])
            0: return 1;
            1: return hw;
            2: return m_en[i];
            3: return m_sel[i] ? m_en[i] : hw;
            default: return m_sel[i] ? 1 : hw;
        endcase
    endfunction

    function automatic int model_status(int i);
        return hist[i][0];
    endfunction

    function automatic logic [31:0] model_word(int i);
        logic [31:0] w = '0;
        w[8] = model_status(i[2:0]) != 0;                       // R4 status at bit 8
        if (kind_of[i] == 2 || kind_of[i] == 3) w[0] = m_en[i] != 0;
        if (kind_of[i] == 4) w[0] = 1'b1;                       // R7 enable reads 1
        if (kind_of[i] == 3 || kind_of[i] == 4) w[4] = m_sel[i] != 0;
        return w;
    endfunction

    function automatic string gate_tag(int i);
        case (kind_of[i])
            0: return "R8";
            1: return "R5";
            2: return "R6 R3";
            3: return "R2 R3 R10";
            default: return "R7";
        endcase
    endfunction

    // Advance the model on each rising edge, using the inputs held since the last falling edge.
    always @(posedge clk) begin
        for (int i = 0; i < NINST; i++) begin
            if (!rst_n) begin
                // R9 reset values of the fields
                m_en[i]  = (kind_of[i] == 2) ? 1 : (kind_of[i] == 3 ? sw_init[i] : 0);
                m_sel[i] = (kind_of[i] == 3) ? sw_init[i] : 0;
                hist[i]  = '{0, 0};
            end else begin
                hist[i].push_back(model_gate(i, int'(hw_req)));
                void'(hist[i].pop_front());
                if (wr_en) begin
                    if (kind_of[i] == 2 || kind_of[i] == 3) m_en[i] = int'(wr_data[0]);
                    if (kind_of[i] == 3 || kind_of[i] == 4) m_sel[i] = int'(wr_data[4]);
                end
            end
        end
        started = 1'b1;
    end

    task automatic compare();
        if (!started) return;
        for (int i = 0; i < NINST; i++) begin
            logic [31:0] ew = model_word(i);
            logic        eg = model_gate(i, int'(hw_req)) != 0;
            vectors++;
            if (rd_v[i] !== ew) begin
                errors++;
                $display("FAIL R1 R4 R9 R10 inst %0d read word: got %h expected %h at %0t",
                         i, rd_v[i], ew, $time);
            end
            vectors++;
            if (ge_v[i] !== eg) begin
                errors++;
                $display("FAIL %s inst %0d gate_en: got %b expected %b at %0t",
                         gate_tag(i), i, ge_v[i], eg, $time);
            end
        end
    endtask

    // One cycle: check at the falling edge, then drive the next inputs.
    task automatic step(input logic rst, input logic we, input logic [31:0] d, input logic hw);
        @(negedge clk);
        compare();
        rst_n   = rst;
        wr_en   = we;
        wr_data = d;
        hw_req  = hw;
    endtask

    task automatic idle(input int n, input logic hw);
        for (int k = 0; k < n; k++) step(1'b1, 1'b0, 32'h0, hw);
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        logic [31:0] lfsr = 32'h1D0F_5A3C;
        // Reset held for a few cycles; R9 reset values are checked here.
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 32'h0, 1'b0);
        idle(3, 1'b0);
        // Hardware request toggles: R5, R7 and R2 (selectable started in hardware mode).
        idle(3, 1'b1);
        idle(1, 1'b0);
        idle(2, 1'b1);
        // Software mode with the enable opposite to hw_req: R2, R3, R10.
        step(1'b1, 1'b1, 32'h0000_0010, 1'b1);
        idle(3, 1'b1);
        step(1'b1, 1'b1, 32'h0000_0011, 1'b0);
        idle(3, 1'b0);
        // Back to hardware mode: R2, R7.
        step(1'b1, 1'b1, 32'h0000_0001, 1'b0);
        idle(2, 1'b1);
        idle(2, 1'b0);
        // All ones and all zeros: R1, R6, R8, R7 ignore what they must.
        step(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
        idle(3, 1'b0);
        step(1'b1, 1'b1, 32'h0000_0000, 1'b1);
        idle(3, 1'b1);
        // Pseudo-random run with a reset in the middle: R4 lag at every transition.
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step((k % 200) != 100, lfsr[7] & lfsr[3], lfsr, lfsr[12]);
        end
        idle(4, 1'b0);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: got timeout expected completion");
            finish_run();
        end
    end
endmodule